// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit is an execution-stage slice for a 64-bit integer pipeline. It computes one of fourteen bit-manipulation and conditional-move results from two source operands, the current value of the destination register, and two 6-bit immediates. The immediates are an upper and a lower field bound, or a rotate or bit index.

The issuing logic presents an operation with `in_valid`. Exactly one clock later the unit raises `out_valid` together with the registered result and a write-enable for the register file. Instruction decoding happens upstream. The unit only sees a 4-bit operation code.

Two kinds of operation can leave the destination untouched: a field extract whose lower bound is above its upper bound, and an unassigned operation code. In both cases the unit reports completion with the write-enable low.

Top module: `bmx_unit`

## Requirements
- R1: `out_valid` is asserted in the cycle after each cycle in which `in_valid` is high, and is low otherwise. `out_wen` is never high without `out_valid`. `out_data` changes only on a clock where `in_valid` was high.
- R2: Operation codes 0, 1 and 2 return `src_a + (src_b << k)` modulo 2^64, with k equal to 1, 2 and 3 respectively. The shift is applied to `src_b`. Write-enable is high.
- R3: Code 3 rotates `src_a` right by `imm_lo` bit positions.
- R4: Codes 4 (signed) and 5 (unsigned) return bits `[imm_hi:imm_lo]` of `src_a`, shifted down to bit 0. Code 4 fills the upper bits with `src_a[imm_hi]`; code 5 fills them with zero.
- R5: For codes 4 and 5 with `imm_lo > imm_hi`, the write-enable is low and `out_data` is zero.
- R6: Code 6 returns the count of leading ones of `src_a`, that is, the leading-zero count of its inverse. Code 7 returns the leading-zero count of `src_a`. A count over an input with no qualifying bit set is 64.
- R7: Code 8 reverses the order of all eight bytes of `src_a`. Code 9 reverses the four bytes of `src_a[31:0]` and sign-extends bit 31 of that reversed word to 64 bits.
- R8: Code 10 sets each result byte to 0xFF when the same byte of `src_a` is zero, and to 0x00 when it is not.
- R9: Code 11 returns `src_a[imm_lo]` in bit 0, with bits 63:1 zero.
- R10: Code 12 returns `src_a` when `src_b` is zero and `dst_old` otherwise. Code 13 returns `src_a` when `src_b` is non-zero and `dst_old` otherwise. Both assert write-enable.
- R11: Codes 14 and 15 complete with `out_wen` low and `out_data` zero.
- R12: While `rst_n` is low, `out_valid`, `out_wen` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see requirements) |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| dst_old | input | 64 | Current destination value |
| imm_hi | input | 6 | Upper field bound |
| imm_lo | input | 6 | Lower field bound, rotate amount or bit index |
| out_valid | output | 1 | Result present, one cycle after `in_valid` |
| out_wen | output | 1 | Destination write-enable |
| out_data | output | 64 | Registered result |

## Verification
The assertions assume that `in_valid`, `op` and the operands are known values at every sampled clock edge after reset. They also assume that `in_valid` is held low while reset is asserted, so the first cycle after release reports nothing.

The stimulus meets these assumptions in three ways:
- It drives every input on the falling edge.
- It keeps `in_valid` low through reset.
- It fills every operand with a defined value on idle cycles, not only on issue cycles.

Random operation codes cover the full 4-bit space, so the two unassigned codes and reversed field bounds both occur.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  localparam int DATA_W = 64;

  typedef enum logic [3:0] {
    OP_ADDSH1 = 4'd0,
    OP_ADDSH2 = 4'd1,
    OP_ADDSH3 = 4'd2,
    OP_ROTR   = 4'd3,
    OP_EXTS   = 4'd4,
    OP_EXTU   = 4'd5,
    OP_LONES  = 4'd6,
    OP_LZEROS = 4'd7,
    OP_REV64  = 4'd8,
    OP_REV32  = 4'd9,
    OP_ZBYTE  = 4'd10,
    OP_BTEST  = 4'd11,
    OP_MVZ    = 4'd12,
    OP_MVNZ   = 4'd13,
    OP_RSV14  = 4'd14,
    OP_RSV15  = 4'd15
  } bmx_op_e;
endpackage

// File: rtl/bmx_lzc.sv
module bmx_lzc #(
  parameter  int W  = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  // Priority scan: the highest set bit wins; an empty vector counts W.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bmx_bytes.sv
module bmx_bytes #(
  parameter  int W     = 64,
  parameter  int WORD  = 32,
  localparam int NB    = W / 8,
  localparam int NBW   = WORD / 8
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] rev_full,
  output logic [W-1:0] rev_word,
  output logic [W-1:0] zero_mask
);
  logic [WORD-1:0] word_sw;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign rev_full[8*g +: 8]  = src[8*(NB-1-g) +: 8];
    assign zero_mask[8*g +: 8] = (src[8*g +: 8] == 8'h00) ? 8'hFF : 8'h00;
  end

  for (genvar g = 0; g < NBW; g++) begin : g_word
    assign word_sw[8*g +: 8] = src[8*(NBW-1-g) +: 8];
  end

  assign rev_word = {{(W-WORD){word_sw[WORD-1]}}, word_sw};
endmodule

// File: rtl/bmx_field.sv
module bmx_field #(
  parameter  int W   = 64,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   src,
  input  logic [SHW-1:0] hi,
  input  logic [SHW-1:0] lo,
  output logic [W-1:0]   rot,
  output logic [W-1:0]   ext_u,
  output logic [W-1:0]   ext_s,
  output logic           fld_ok
);
  logic [2*W-1:0] dbl;
  logic [SHW:0]   len;
  logic [W-1:0]   mask;
  logic [W-1:0]   down;

  assign dbl    = {src, src} >> lo;
  assign rot    = dbl[W-1:0];
  assign fld_ok = (lo <= hi);
  assign len    = {1'b0, hi} - {1'b0, lo} + (SHW+1)'(1);
  assign mask   = ~({W{1'b1}} << len);
  assign down   = src >> lo;
  assign ext_u  = down & mask;
  assign ext_s  = ext_u | (src[hi] ? ~mask : '0);
endmodule

// File: rtl/bmx_unit.sv
module bmx_unit
  import bmx_pkg::*;
#(
  parameter  int W   = DATA_W,
  localparam int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [3:0]     op,
  input  logic [W-1:0]   src_a,
  input  logic [W-1:0]   src_b,
  input  logic [W-1:0]   dst_old,
  input  logic [SHW-1:0] imm_hi,
  input  logic [SHW-1:0] imm_lo,
  output logic           out_valid,
  output logic           out_wen,
  output logic [W-1:0]   out_data
);
  localparam int CW = SHW + 1;

  bmx_op_e      op_e;
  logic [W-1:0] rot, ext_u, ext_s, rev_full, rev_word, zmask;
  logic         fld_ok;
  logic [CW-1:0] cnt_ones, cnt_zeros;
  logic [W-1:0] nxt_data;
  logic         nxt_wen;

  assign op_e = bmx_op_e'(op);

  bmx_field #(.W(W)) u_field (
    .src(src_a), .hi(imm_hi), .lo(imm_lo),
    .rot(rot), .ext_u(ext_u), .ext_s(ext_s), .fld_ok(fld_ok)
  );

  bmx_bytes #(.W(W), .WORD(W/2)) u_bytes (
    .src(src_a), .rev_full(rev_full), .rev_word(rev_word), .zero_mask(zmask)
  );

  bmx_lzc #(.W(W)) u_lz_ones  (.vec(~src_a), .cnt(cnt_ones));
  bmx_lzc #(.W(W)) u_lz_zeros (.vec(src_a),  .cnt(cnt_zeros));

  // Next-state: result selection
  always_comb begin
    nxt_data = '0;
    nxt_wen  = 1'b1;
    unique case (op_e)
      OP_ADDSH1: nxt_data = src_a + (src_b << 1);
      OP_ADDSH2: nxt_data = src_a + (src_b << 2);
      OP_ADDSH3: nxt_data = src_a + (src_b << 3);
      OP_ROTR:   nxt_data = rot;
      OP_EXTS:   begin nxt_data = fld_ok ? ext_s : '0; nxt_wen = fld_ok; end
      OP_EXTU:   begin nxt_data = fld_ok ? ext_u : '0; nxt_wen = fld_ok; end
      OP_LONES:  nxt_data = {{(W-CW){1'b0}}, cnt_ones};
      OP_LZEROS: nxt_data = {{(W-CW){1'b0}}, cnt_zeros};
      OP_REV64:  nxt_data = rev_full;
      OP_REV32:  nxt_data = rev_word;
      OP_ZBYTE:  nxt_data = zmask;
      OP_BTEST:  nxt_data = {{(W-1){1'b0}}, src_a[imm_lo]};
      OP_MVZ:    nxt_data = (src_b == '0) ? src_a : dst_old;
      OP_MVNZ:   nxt_data = (src_b != '0) ? src_a : dst_old;
      default:   begin nxt_data = '0; nxt_wen = 1'b0; end
    endcase
  end

  // Register stage with explicit enable on the data path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wen   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_wen   <= in_valid & nxt_wen;
      if (in_valid) out_data <= nxt_data;
    end
  end

  a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_wen_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> out_valid);
  a_r1_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  a_r5_bad_field_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_e == OP_EXTS || op_e == OP_EXTU) && imm_lo > imm_hi)
      |=> !out_wen);
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ones <= CW'(W)) && (cnt_zeros <= CW'(W)));
  a_r6_counts_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ones == '0) || (cnt_zeros == '0));
  a_r9_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == OP_BTEST) |=> (out_data[W-1:1] == '0));
  a_r10_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == OP_MVZ && src_b != '0) |=> (out_data == $past(dst_old)));
  a_r11_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[3:1] == 3'b111) |=> (!out_wen && out_data == '0));
endmodule

// File: tb/bmx_unit_tb.sv
module bmx_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [63:0] src_a, src_b, dst_old;
  logic [5:0]  imm_hi, imm_lo;
  logic        out_valid, out_wen;
  logic [63:0] out_data;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic        e_valid, e_wen;
  logic [63:0] e_data;
  string       e_req;

  always #5 clk = ~clk;

  bmx_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .imm_hi(imm_hi), .imm_lo(imm_lo),
    .out_valid(out_valid), .out_wen(out_wen), .out_data(out_data)
  );

  function automatic int lead_zeros(logic [63:0] x);
    int n = 0;
    while (n < 64 && !x[63-n]) n++;
    return n;
  endfunction

  function automatic void model(input logic [3:0] o, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] d, input int hi, input int lo,
      output logic w, output logic [63:0] r, output string req);
    logic [31:0] wd;
    w = 1'b1; r = '0;
    case (o)
      0, 1, 2: begin req = "R2"; r = a + b * (64'd1 << (o + 1)); end
      3: begin req = "R3";
        for (int i = 0; i < 64; i++) r[i] = a[(i + lo) % 64]; end
      4, 5: begin
        if (lo > hi) begin req = "R5"; w = 1'b0; end
        else begin
          req = "R4";
          for (int i = 0; i < 64; i++)
            r[i] = (i <= hi - lo) ? a[lo + i] : ((o == 4) ? a[hi] : 1'b0);
        end
      end
      6: begin req = "R6"; r = 64'(lead_zeros(~a)); end
      7: begin req = "R6"; r = 64'(lead_zeros(a)); end
      8: begin req = "R7";
        for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8]; end
      9: begin req = "R7";
        wd = {a[7:0], a[15:8], a[23:16], a[31:24]};
        r = {{32{wd[31]}}, wd}; end
      10: begin req = "R8";
        for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] == 0) ? 8'hFF : 8'h00; end
      11: begin req = "R9"; r = {63'd0, a[lo]}; end
      12: begin req = "R10"; r = (b == 0) ? a : d; end
      13: begin req = "R10"; r = (b != 0) ? a : d; end
      default: begin req = "R11"; w = 1'b0; end
    endcase
  endfunction

  task automatic compare();
    vectors++;
    if (out_valid !== e_valid || out_wen !== e_wen || out_data !== e_data) begin
      miscompares++;
      $display("FAIL %s: got v=%0b w=%0b d=%h, expected v=%0b w=%0b d=%h",
               e_req, out_valid, out_wen, out_data, e_valid, e_wen, e_data);
    end
  endtask

  // Drive on the falling edge, check on the next falling edge.
  task automatic apply(input logic v, input logic [3:0] o, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] d, input int hi, input int lo);
    logic w; logic [63:0] r; string req;
    in_valid = v; op = o; src_a = a; src_b = b; dst_old = d;
    imm_hi = 6'(hi); imm_lo = 6'(lo);
    if (v) begin
      model(o, a, b, d, hi, lo, w, r, req);
      e_valid = 1'b1; e_wen = w; e_data = r; e_req = req;
    end else begin
      e_valid = 1'b0; e_wen = 1'b0; e_req = "R1";
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; src_a = '0; src_b = '0;
    dst_old = '0; imm_hi = '0; imm_lo = '0;
    repeat (3) @(negedge clk);
    e_valid = 0; e_wen = 0; e_data = '0; e_req = "R12";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    e_req = "R12"; compare();

    // R2 shifted add scales second operand
    apply(1, 0, 64'd100, 64'd7, 0, 0, 0);
    apply(1, 2, 64'hFFFF_FFFF_FFFF_FFF0, 64'd3, 0, 0, 0);
    // R3 rotate, including zero and maximal amount
    apply(1, 3, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 4);
    apply(1, 3, 64'h8000_0000_0000_0001, 0, 0, 0, 0);
    apply(1, 3, 64'h8000_0000_0000_0001, 0, 0, 0, 63);
    // R4 extracts, whole-word and single-bit fields
    apply(1, 4, 64'h0000_0000_0000_F000, 0, 0, 15, 12);
    apply(1, 5, 64'h0000_0000_0000_F000, 0, 0, 15, 12);
    apply(1, 4, 64'hDEAD_BEEF_0000_0000, 0, 0, 63, 0);
    apply(1, 4, 64'h0000_0000_0000_0020, 0, 0, 5, 5);
    // R5 reversed bounds: no write
    apply(1, 4, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 3, 9);
    apply(1, 5, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 63);
    // R1 idle cycle: data holds
    apply(0, 0, 64'h1234, 64'h5678, 0, 0, 0);
    // R6 counts, all-zero and all-one inputs give 64
    apply(1, 7, 64'd0, 0, 0, 0, 0);
    apply(1, 6, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
    apply(1, 7, 64'h0000_0001_0000_0000, 0, 0, 0, 0);
    apply(1, 6, 64'hFF00_0000_0000_0000, 0, 0, 0, 0);
    // R7 byte reversal, positive and negative word results
    apply(1, 8, 64'h0102_0304_0506_0708, 0, 0, 0, 0);
    apply(1, 9, 64'hAAAA_AAAA_0000_0080, 0, 0, 0, 0);
    apply(1, 9, 64'hAAAA_AAAA_7F00_0000, 0, 0, 0, 0);
    // R8 zero-byte test
    apply(1, 10, 64'h00FF_0012_0000_3400, 0, 0, 0, 0);
    // R9 bit test
    apply(1, 11, 64'h8000_0000_0000_0000, 0, 0, 0, 63);
    apply(1, 11, 64'h8000_0000_0000_0000, 0, 0, 0, 62);
    // R10 conditional moves
    apply(1, 12, 64'h1111, 64'd0, 64'h2222, 0, 0);
    apply(1, 12, 64'h1111, 64'd5, 64'h2222, 0, 0);
    apply(1, 13, 64'h3333, 64'd5, 64'h4444, 0, 0);
    apply(1, 13, 64'h3333, 64'd0, 64'h4444, 0, 0);
    // R11 reserved codes
    apply(1, 14, 64'h5555, 64'd1, 64'd2, 1, 1);
    apply(1, 15, 64'h5555, 64'd1, 64'd2, 1, 1);

    // Mixed random traffic with idle gaps
    for (int n = 0; n < 400; n++) begin
      logic [63:0] ra, rb, rd;
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom}; rd = {$urandom, $urandom};
      if (n % 5 == 0) rb = '0;
      if (n % 7 == 0) ra[31:16] = '0;
      apply(($urandom % 4) != 0, 4'($urandom), ra, rb, rd,
            int'($urandom % 64), int'($urandom % 64));
    end

    // R12 asynchronous reset clears outputs
    apply(1, 8, 64'h0102_0304_0506_0708, 0, 0, 0, 0);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    e_valid = 0; e_wen = 0; e_data = '0; e_req = "R12";
    compare();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule